// File: doc/BRIEF.md
# Restricted-Collapse Issue Queue Entry Manager

This block keeps the slot bookkeeping of an age-ordered issue queue. Slot 0 is the oldest position and slots fill upward from a tail pointer, so the slot index is also the age order. When select issues instructions, their slots become holes. A conventional queue would shift every younger entry down to close them. Here only the part of the queue at or above a rotating pseudo-head compacts. Each cycle, everything above the lowest hole in that region moves down one slot. Entries below the pseudo-head stay where they are, and their holes stay open until the pseudo-head wraps back below them.

The pseudo-head steps forward by one slot every `RR_PERIOD` cycles and wraps at the depth, which spreads shifting activity over all slots. The block drives a per-slot shift vector and a per-slot clock enable, so slots whose contents do not change are not clocked. It also exports an age rank per slot for the select logic.

New instructions arrive on a valid/ready port. An allocation is accepted in a cycle when `in_valid_i` and `in_ready_o` are both high. The index it takes is shown on `alloc_idx_o` in that same cycle. While `in_ready_o` is low, a pending `in_valid_i` is held off and has no effect. A flush empties the queue and takes priority over allocation and issue.

Top module: `rc_issue_queue`

## Requirements
- R1: After reset, and in the cycle after a flush, no slot is valid, the pseudo-head is 0, `alloc_idx_o` is 0, `full_o` is 0 and `in_ready_o` is 1.
- R2: An accepted allocation writes the slot given by `alloc_idx_o`. That index is the tail count, less one when a collapse happens in the same cycle. The slot reads valid from the next cycle.
- R3: `full_o` is 1 exactly when the tail count equals DEPTH and no slot shifts this cycle. `in_ready_o` is 0 while `full_o` or `flush_i` is 1. An `in_valid_i` that is not accepted changes no slot.
- R4: Let ph be the pseudo-head. Slot j shifts (`shift_o[j]`=1) when ph <= j < tail and some slot in [ph, j] is empty after this cycle's issues. A shifting slot takes the contents of slot j+1, and the top slot becomes empty.
- R5: Slots below the pseudo-head never shift, and a hole among them stays a hole.
- R6: A bit of `issue_i` on a slot that is not valid has no effect on any slot, on the shift vector or on the clock enables.
- R7: `clk_en_o[j]` is 1 exactly when slot j shifts, a valid slot j issues, or an accepted allocation writes slot j.
- R8: The pseudo-head advances by one every RR_PERIOD cycles after a flush or reset, and wraps from DEPTH-1 to 0.
- R9: `rank_o[j*IDXW +: IDXW]` is the number of valid slots with an index below j, so holes are skipped and a lower rank is older.
- R10: A flush overrides allocation and issue in the same cycle, and `in_ready_o` is 0 during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empties the queue and restarts the pseudo-head |
| in_valid_i | input | 1 | Allocation request |
| in_ready_o | output | 1 | Allocation can be accepted this cycle |
| alloc_idx_o | output | IDXW | Slot written by an accepted allocation |
| issue_i | input | DEPTH | Per-slot issue from select |
| full_o | output | 1 | No slot can be allocated this cycle |
| entry_valid_o | output | DEPTH | Per-slot valid bits |
| shift_o | output | DEPTH | Per-slot collapse vector for this cycle |
| clk_en_o | output | DEPTH | Per-slot clock enable for this cycle |
| rank_o | output | DEPTH*IDXW | Age rank per slot |
| phead_o | output | IDXW | Current pseudo-head |

## Verification
A wrong tail count shows up on `alloc_idx_o` and `full_o` in the same cycle, because both are combinational on it. A wrong pseudo-head shows up on `shift_o` as soon as an issue lands near the region boundary. A corrupted valid vector shows up one cycle later on `entry_valid_o` and on the ranks. The directed scenarios are built so that each of these faults meets an exact expected value within a cycle or two: a boundary collapse, an issue into a hole, full with and without a freeing issue, and pseudo-head wrap.

// File: rtl/rc_iq_pkg.sv
package rc_iq_pkg;
  // next pointer value in a ring of 'depth' slots
  function automatic int unsigned rc_wrap_next(input int unsigned cur, input int unsigned depth);
    return (cur >= depth - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/rc_phead_rotor.sv
module rc_phead_rotor #(
  parameter int DEPTH     = 8,
  parameter int RR_PERIOD = 16,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = (RR_PERIOD < 2) ? 1 : $clog2(RR_PERIOD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush_i,
  output logic [IDXW-1:0] ph_o
);
  import rc_iq_pkg::*;
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_o  <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
      ph_o  <= '0;
    end else if (cnt_q == CNTW'(RR_PERIOD - 1)) begin
      cnt_q <= '0;
      ph_o  <= IDXW'(rc_wrap_next(32'(ph_o), DEPTH));
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rc_collapse_plan.sv
module rc_collapse_plan #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int TW   = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] valid_i,
  input  logic [DEPTH-1:0] issue_i,
  input  logic [IDXW-1:0]  ph_i,
  input  logic [TW-1:0]    tail_i,
  output logic [DEPTH-1:0] live_o,
  output logic [DEPTH-1:0] shift_o,
  output logic             collapse_o
);
  logic [DEPTH-1:0] in_reg, gap, seen;

  assign live_o = valid_i & ~issue_i;

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    localparam logic [IDXW-1:0] JI = IDXW'(j);
    localparam logic [TW-1:0]   JT = TW'(j);
    assign in_reg[j] = (ph_i <= JI) && (JT < tail_i);
    assign gap[j]    = in_reg[j] & ~live_o[j];
    if (j == 0) begin : g_first
      assign seen[j] = gap[j];
    end else begin : g_rest
      assign seen[j] = seen[j-1] | gap[j];
    end
    assign shift_o[j] = in_reg[j] & seen[j];
  end

  assign collapse_o = |shift_o;
endmodule

// File: rtl/rc_age_rank.sv
module rc_age_rank #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic [DEPTH-2:0]      valid_i,
  output logic [DEPTH*IDXW-1:0] rank_o
);
  logic [IDXW-1:0] cnt [DEPTH];

  assign cnt[0] = '0;
  for (genvar j = 1; j < DEPTH; j++) begin : g_cnt
    assign cnt[j] = cnt[j-1] + IDXW'(valid_i[j-1]);
  end
  for (genvar j = 0; j < DEPTH; j++) begin : g_out
    assign rank_o[j*IDXW +: IDXW] = cnt[j];
  end
endmodule

// File: rtl/rc_issue_queue.sv
module rc_issue_queue #(
  parameter int DEPTH     = 8,
  parameter int RR_PERIOD = 16,
  localparam int IDXW = $clog2(DEPTH),
  localparam int TW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  output logic [IDXW-1:0]       alloc_idx_o,
  input  logic [DEPTH-1:0]      issue_i,
  output logic                  full_o,
  output logic [DEPTH-1:0]      entry_valid_o,
  output logic [DEPTH-1:0]      shift_o,
  output logic [DEPTH-1:0]      clk_en_o,
  output logic [DEPTH*IDXW-1:0] rank_o,
  output logic [IDXW-1:0]       phead_o
);
  logic [DEPTH-1:0] valid_q, valid_n, live, shift_v;
  logic [TW-1:0]    tail_q, tail_n, alloc_pos;
  logic             collapse, accept;

  rc_phead_rotor #(.DEPTH(DEPTH), .RR_PERIOD(RR_PERIOD)) u_rotor (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .ph_o(phead_o));

  rc_collapse_plan #(.DEPTH(DEPTH)) u_plan (
    .valid_i(valid_q), .issue_i(issue_i), .ph_i(phead_o), .tail_i(tail_q),
    .live_o(live), .shift_o(shift_v), .collapse_o(collapse));

  rc_age_rank #(.DEPTH(DEPTH)) u_rank (
    .valid_i(valid_q[DEPTH-2:0]), .rank_o(rank_o));

  assign full_o      = (tail_q == TW'(DEPTH)) && !collapse;
  assign in_ready_o  = !full_o && !flush_i;
  assign accept      = in_valid_i && in_ready_o;
  assign alloc_pos   = tail_q - TW'(collapse);
  assign alloc_idx_o = IDXW'(alloc_pos);
  assign shift_o     = shift_v;
  assign entry_valid_o = valid_q;
  assign tail_n      = tail_q - TW'(collapse) + TW'(accept);

  for (genvar j = 0; j < DEPTH; j++) begin : g_next
    localparam logic [TW-1:0] JT = TW'(j);
    logic moved, wr_here;
    if (j == DEPTH - 1) begin : g_top
      assign moved = shift_v[j] ? 1'b0 : live[j];
    end else begin : g_mid
      assign moved = shift_v[j] ? live[j+1] : live[j];
    end
    assign wr_here     = accept && (alloc_pos == JT);
    assign valid_n[j]  = moved | wr_here;
    assign clk_en_o[j] = shift_v[j] | (issue_i[j] & valid_q[j]) | wr_here;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      tail_q  <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
      tail_q  <= '0;
    end else begin
      valid_q <= valid_n;
      tail_q  <= tail_n;
    end
  end
endmodule

// File: rtl/rc_iq_checker.sv
module rc_iq_checker #(
  parameter int DEPTH     = 8,
  parameter int RR_PERIOD = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush_i,
  input logic                  in_valid_i,
  input logic                  in_ready_o,
  input logic [IDXW-1:0]       alloc_idx_o,
  input logic                  full_o,
  input logic [DEPTH-1:0]      entry_valid_o,
  input logic [DEPTH-1:0]      shift_o,
  input logic [DEPTH-1:0]      clk_en_o,
  input logic [IDXW-1:0]       phead_o
);
  import rc_iq_pkg::*;
  logic [DEPTH-1:0] below_ph;
  logic             acc_q;
  logic [IDXW-1:0]  acc_idx_q;

  assign below_ph = (DEPTH'(1) << phead_o) - DEPTH'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= 1'b0;
      acc_idx_q <= '0;
    end else begin
      acc_q     <= in_valid_i && in_ready_o;
      acc_idx_q <= alloc_idx_o;
    end
  end

  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !in_ready_o);
  p_flush_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !in_ready_o);
  p_flush_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (entry_valid_o == '0) && (phead_o == '0));
  p_accept_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> entry_valid_o[acc_idx_q]);
  p_no_shift_below_ph_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_o & below_ph) == '0);
  p_shift_clocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_o & ~clk_en_o) == '0);
  p_ph_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(flush_i) && !$stable(phead_o)) |->
      (32'(phead_o) == rc_wrap_next(32'($past(phead_o)), DEPTH)));
endmodule

bind rc_issue_queue rc_iq_checker #(.DEPTH(DEPTH), .RR_PERIOD(RR_PERIOD)) u_rc_iq_checker (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .alloc_idx_o(alloc_idx_o), .full_o(full_o),
  .entry_valid_o(entry_valid_o), .shift_o(shift_o), .clk_en_o(clk_en_o),
  .phead_o(phead_o));

// File: tb/rc_issue_queue_bench.sv
module rc_issue_queue_bench;
  localparam int DEPTH = 8;
  localparam int IDXW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush_i = 1'b0, in_valid_i = 1'b0;
  logic [DEPTH-1:0] issue_i = '0;
  logic in_ready_o, full_o;
  logic [IDXW-1:0] alloc_idx_o, phead_o;
  logic [DEPTH-1:0] entry_valid_o, shift_o, clk_en_o;
  logic [DEPTH*IDXW-1:0] rank_o;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  rc_issue_queue #(.DEPTH(DEPTH), .RR_PERIOD(16)) u_rc_issue_queue (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .alloc_idx_o(alloc_idx_o), .issue_i(issue_i),
    .full_o(full_o), .entry_valid_o(entry_valid_o), .shift_o(shift_o),
    .clk_en_o(clk_en_o), .rank_o(rank_o), .phead_o(phead_o));

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [DEPTH-1:0] iss);
    @(negedge clk);
    flush_i = 1'b0; in_valid_i = v; issue_i = iss;
    #1;
  endtask

  task automatic do_flush(input logic v, input logic [DEPTH-1:0] iss);
    @(negedge clk);
    flush_i = 1'b1; in_valid_i = v; issue_i = iss;
    #1;
    chk("R10 ready low in flush", 32'(in_ready_o), 0);
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) begin
      step(1'b1, '0);
      chk("R2 alloc index at tail", 32'(alloc_idx_o), 32'(k));
    end
  endtask

  function automatic logic [31:0] rank_of(input int j);
    return 32'(rank_o[j*IDXW +: IDXW]);
  endfunction

  task automatic t_reset;
    chk("R1 reset valid", 32'(entry_valid_o), 0);
    chk("R1 reset ph", 32'(phead_o), 0);
    chk("R1 reset idx", 32'(alloc_idx_o), 0);
    chk("R1 reset full", 32'(full_o), 0);
    chk("R1 reset ready", 32'(in_ready_o), 1);
  endtask

  task automatic t_fill_full;
    do_flush(1'b0, '0);
    fill(8);
    step(1'b1, '0);
    chk("R3 full at depth", 32'(full_o), 1);
    chk("R3 ready low when full", 32'(in_ready_o), 0);
    chk("R2 all slots valid", 32'(entry_valid_o), 32'hFF);
    step(1'b0, '0);
    chk("R3 refused request no change", 32'(entry_valid_o), 32'hFF);
  endtask

  task automatic t_collapse;
    do_flush(1'b0, '0);
    fill(8);
    step(1'b0, 8'h04);
    chk("R3 freeing issue clears full", 32'(full_o), 0);
    chk("R4 shift above hole", 32'(shift_o), 32'hFC);
    chk("R7 clk_en on shift", 32'(clk_en_o), 32'hFC);
    chk("R2 idx during collapse", 32'(alloc_idx_o), 7);
    step(1'b1, 8'h01);
    chk("R4 compacted valid", 32'(entry_valid_o), 32'h7F);
    chk("R4 shift from slot0", 32'(shift_o), 32'h7F);
    chk("R2 idx tail minus one", 32'(alloc_idx_o), 6);
    chk("R7 clk_en shift+alloc", 32'(clk_en_o), 32'h7F);
    step(1'b0, '0);
    chk("R2 alloc during collapse", 32'(entry_valid_o), 32'h7F);
    chk("R7 idle no clk_en", 32'(clk_en_o), 0);
    chk("R9 rank slot6", rank_of(6), 6);
    chk("R9 rank slot7", rank_of(7), 7);
  endtask

  task automatic t_ignore_issue;
    do_flush(1'b0, '0);
    fill(3);
    step(1'b0, 8'h20);
    chk("R6 empty issue no shift", 32'(shift_o), 0);
    chk("R6 empty issue no clk_en", 32'(clk_en_o), 0);
    step(1'b0, 8'h04);
    chk("R6 valid unchanged", 32'(entry_valid_o), 32'h07);
    chk("R4 youngest issue shift", 32'(shift_o), 32'h04);
    chk("R2 idx after youngest issue", 32'(alloc_idx_o), 2);
    step(1'b0, '0);
    chk("R4 youngest removed", 32'(entry_valid_o), 32'h03);
    chk("R2 tail shrank", 32'(alloc_idx_o), 2);
  endtask

  task automatic t_pseudo_head;
    do_flush(1'b0, '0);
    fill(8);
    for (int k = 9; k <= 32; k++) step(1'b0, '0);
    step(1'b0, 8'h01);
    chk("R8 ph after two periods", 32'(phead_o), 2);
    chk("R5 no shift below ph", 32'(shift_o), 0);
    chk("R5 still full", 32'(full_o), 1);
    chk("R7 clk_en issue only", 32'(clk_en_o), 32'h01);
    step(1'b1, 8'h20);
    chk("R5 hole kept below ph", 32'(entry_valid_o), 32'hFE);
    chk("R4 shift above ph", 32'(shift_o), 32'hE0);
    chk("R2 idx", 32'(alloc_idx_o), 7);
    chk("R7 clk_en region", 32'(clk_en_o), 32'hE0);
    step(1'b0, '0);
    chk("R5 hole persists", 32'(entry_valid_o), 32'hFE);
    chk("R9 rank skips hole", rank_of(1), 0);
    chk("R9 rank top", rank_of(7), 6);
    chk("R3 full again", 32'(full_o), 1);
  endtask

  task automatic t_rotation;
    do_flush(1'b0, '0);
    for (int k = 1; k <= 129; k++) begin
      step(1'b0, '0);
      if (k == 16)  chk("R8 ph holds", 32'(phead_o), 0);
      if (k == 17)  chk("R8 ph step", 32'(phead_o), 1);
      if (k == 113) chk("R8 ph last", 32'(phead_o), 7);
      if (k == 129) chk("R8 ph wrap", 32'(phead_o), 0);
    end
  endtask

  task automatic t_flush;
    do_flush(1'b0, '0);
    fill(5);
    do_flush(1'b1, 8'h01);
    step(1'b0, '0);
    chk("R1 flush valid", 32'(entry_valid_o), 0);
    chk("R1 flush idx", 32'(alloc_idx_o), 0);
    chk("R1 flush ph", 32'(phead_o), 0);
    chk("R10 flush beats alloc", 32'(full_o), 0);
    chk("R1 ready after flush", 32'(in_ready_o), 1);
  endtask

  initial begin
    #50000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_fill_full();
    t_collapse();
    t_ignore_issue();
    t_pseudo_head();
    t_rotation();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule